// File: doc/BRIEF.md
# Comparator Control Register with Clock-Domain Handshake

This block holds the 8-bit top-level control byte of an analog comparator pair. Software writes it from the bus clock domain. Two fields, the peripheral on/off switch and a one-shot software reset, must act in the separate peripheral clock domain. They cross through a toggle request and acknowledge handshake with multi-flop synchronizers in both directions. A busy flag stays high from the accepted bus write until the acknowledge is seen back in the bus domain.

Two mode fields act at once in the bus domain and drive plain outputs without any crossing: a high-resistance analog-mux select and a keep-running-during-standby select. A software reset request takes priority over all other fields of the same write. When the request completes, the peripheral domain sees a single-cycle reset pulse that clears its other registers, the peripheral is switched off, and the whole byte returns to zero. A lock input stands in for write protection. While it is high, writes are dropped. Reads are always open.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After reset the read value is 0x00, busy is low, both mode outputs are low and the peripheral enable is low.
- R2: An accepted write that changes bit 1 (enable) while idle shows the new bit 1 on the read port and raises busy on the next bus clock.
- R3: The peripheral-domain enable takes the written value only after the synchronizer delay. Busy clears only after that change has been acknowledged back to the bus domain.
- R4: An accepted write with bit 0 (software reset) set while idle sets read bit 0 and raises busy. Every other bit of that write is discarded, and bits 7, 2 and 1 keep their earlier values.
- R5: When a software reset completes, the peripheral domain gives exactly one reset pulse with the enable low. The read value then becomes 0x00, busy falls and both mode outputs go low.
- R6: A write with bit 0 clear that keeps bit 1 at its current value starts no transfer, and busy stays low.
- R7: Bit 7 (mux select) and bit 2 (run in standby) of an accepted write reach their outputs on the next bus clock, including while busy.
- R8: While busy is high, bits 1 and 0 of any write are ignored. Bits 7 and 2 are still written.
- R9: While lock is high, writes change nothing.
- R10: Bits 6 to 3 always read as zero, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst_n | input | 1 | Bus domain active-low reset |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_data | input | 8 | Write byte |
| lock | input | 1 | When high, writes are dropped |
| rd_data | output | 8 | Current register contents |
| lpmux_sel | output | 1 | High-resistance analog mux select (bit 7) |
| stby_run | output | 1 | Keep comparators running in standby (bit 2) |
| busy | output | 1 | Enable or reset transfer in flight |
| per_clk | input | 1 | Peripheral domain clock |
| per_rst_n | input | 1 | Peripheral domain active-low reset |
| per_enable | output | 1 | Synchronized peripheral enable |
| per_swrst | output | 1 | One-cycle reset pulse for the peripheral registers |

## Verification
The bench builds the block with SYNC_STAGES = 3 and unrelated clocks of 8 ns and 11 ns. The deeper synchronizer widens the busy window. That leaves room for further writes to land while a transfer is in flight, which is where R8 and the precedence between a reset and other fields are exercised. A scoreboard queue records each expected peripheral-domain event: enable on, enable off or reset. A monitor on the peripheral clock compares the events it observes against that queue.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned BIT_LPMUX = 7;
  localparam int unsigned BIT_STBY  = 2;
  localparam int unsigned BIT_EN    = 1;
  localparam int unsigned BIT_RST   = 0;

  // Command held stable across the clock crossing while busy
  typedef struct packed {
    logic rst;
    logic en;
  } xfer_cmd_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmp_ctrl_bus.sv
module cmp_ctrl_bus
  import cmp_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock,
  input  logic             ack_s,
  output logic [REG_W-1:0] rd_data,
  output logic             lpmux_sel,
  output logic             stby_run,
  output logic             busy,
  output logic             req_tog,
  output xfer_cmd_t        cmd
);
  logic      lpmux_q, stby_q, en_q, rst_q, busy_q, req_q;
  xfer_cmd_t cmd_q;
  logic      wr_ok, start_rst, start_en, mode_wr, done;

  assign done      = busy_q && (req_q == ack_s);
  assign wr_ok     = wr_en && !lock;
  assign start_rst = wr_ok && !busy_q && wr_data[BIT_RST];
  assign start_en  = wr_ok && !busy_q && !wr_data[BIT_RST] && (wr_data[BIT_EN] != en_q);
  assign mode_wr   = wr_ok && !start_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpmux_q <= 1'b0; stby_q <= 1'b0; en_q <= 1'b0; rst_q <= 1'b0;
      busy_q  <= 1'b0; req_q  <= 1'b0; cmd_q <= '0;
    end else if (done && cmd_q.rst) begin
      lpmux_q <= 1'b0; stby_q <= 1'b0; en_q <= 1'b0; rst_q <= 1'b0;
      busy_q  <= 1'b0; cmd_q  <= '0;
    end else begin
      if (done) busy_q <= 1'b0;
      if (mode_wr) begin
        lpmux_q <= wr_data[BIT_LPMUX];
        stby_q  <= wr_data[BIT_STBY];
      end
      if (start_rst) begin
        rst_q  <= 1'b1;
        busy_q <= 1'b1;
        req_q  <= ~req_q;
        cmd_q  <= '{rst: 1'b1, en: 1'b0};
      end else if (start_en) begin
        en_q   <= wr_data[BIT_EN];
        busy_q <= 1'b1;
        req_q  <= ~req_q;
        cmd_q  <= '{rst: 1'b0, en: wr_data[BIT_EN]};
      end
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_LPMUX] = lpmux_q;
    rd_data[BIT_STBY]  = stby_q;
    rd_data[BIT_EN]    = en_q;
    rd_data[BIT_RST]   = rst_q;
  end

  assign lpmux_sel = lpmux_q;
  assign stby_run  = stby_q;
  assign busy      = busy_q;
  assign req_tog   = req_q;
  assign cmd       = cmd_q;

  assert_en_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock && !busy && !wr_data[BIT_RST] && (wr_data[BIT_EN] != rd_data[BIT_EN]))
      |=> (busy && rd_data[BIT_EN] == $past(wr_data[BIT_EN])));
  assert_rst_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock && !busy && wr_data[BIT_RST])
      |=> (busy && rd_data == ($past(rd_data) | 8'h01)));
  assert_rst_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_q.rst) |=> (rd_data == '0 && !busy));
  assert_no_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !wr_data[BIT_RST] && (wr_data[BIT_EN] == rd_data[BIT_EN])) |=> !busy);
  assert_mode_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock && !done && !(wr_data[BIT_RST] && !busy))
      |=> (lpmux_sel == $past(wr_data[BIT_LPMUX]) && stby_run == $past(wr_data[BIT_STBY])));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !done) |=> (rd_data[1:0] == $past(rd_data[1:0])));
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock && !done) |=> $stable(rd_data));
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:3] == 4'b0);
endmodule

// File: rtl/cmp_ctrl_per.sv
module cmp_ctrl_per
  import cmp_ctrl_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_tog,
  input  xfer_cmd_t cmd,
  output logic      ack_tog,
  output logic      per_enable,
  output logic      per_swrst
);
  logic req_s, seen_q, en_q, rst_q;

  cmp_sync #(.STAGES(STAGES), .W(1)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tog), .q(req_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0; en_q <= 1'b0; rst_q <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (req_s != seen_q) begin
        seen_q <= req_s;
        if (cmd.rst) begin
          en_q  <= 1'b0;
          rst_q <= 1'b1;
        end else begin
          en_q <= cmd.en;
        end
      end
    end
  end

  assign ack_tog    = seen_q;
  assign per_enable = en_q;
  assign per_swrst  = rst_q;

  assert_en_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_enable) |-> !$stable(ack_tog));
  assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_swrst |=> !per_swrst);
  assert_rst_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_swrst |-> !per_enable);
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock,
  output logic [REG_W-1:0] rd_data,
  output logic             lpmux_sel,
  output logic             stby_run,
  output logic             busy,
  input  logic             per_clk,
  input  logic             per_rst_n,
  output logic             per_enable,
  output logic             per_swrst
);
  logic      req_tog, ack_tog, ack_s;
  xfer_cmd_t cmd;

  cmp_ctrl_bus u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lock(lock), .ack_s(ack_s), .rd_data(rd_data), .lpmux_sel(lpmux_sel),
    .stby_run(stby_run), .busy(busy), .req_tog(req_tog), .cmd(cmd)
  );

  cmp_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tog), .q(ack_s)
  );

  cmp_ctrl_per #(.STAGES(SYNC_STAGES)) u_per (
    .clk(per_clk), .rst_n(per_rst_n), .req_tog(req_tog), .cmd(cmd),
    .ack_tog(ack_tog), .per_enable(per_enable), .per_swrst(per_swrst)
  );
endmodule

// File: tb/cmp_ctrl_reg_bench.sv
module cmp_ctrl_reg_bench;
  logic       bus_clk = 1'b0, per_clk = 1'b0;
  logic       bus_rst_n = 1'b0, per_rst_n = 1'b0;
  logic       wr_en = 1'b0, lock = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       lpmux_sel, stby_run, busy, per_enable, per_swrst;

  int unsigned n_chk = 0, n_fail = 0;
  logic [1:0]  exp_q [$];       // 0 enable off, 1 enable on, 2 reset
  logic        prev_en = 1'b0;

  always #4    bus_clk = ~bus_clk;
  always #5.5  per_clk = ~per_clk;

  cmp_ctrl_reg #(.SYNC_STAGES(3)) u_cmp_ctrl_reg (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lock(lock), .rd_data(rd_data), .lpmux_sel(lpmux_sel), .stby_run(stby_run),
    .busy(busy), .per_clk(per_clk), .per_rst_n(per_rst_n),
    .per_enable(per_enable), .per_swrst(per_swrst)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 200) begin
      @(negedge bus_clk);
      n++;
    end
    chk(!busy, req, busy, 0);
  endtask

  // Monitor: peripheral-domain events compared against the scoreboard
  initial begin
    forever begin
      @(negedge per_clk);
      if (per_rst_n) begin
        logic [1:0] got;
        logic       ev;
        ev = 1'b0; got = 2'd0;
        if (per_swrst) begin
          ev = 1'b1; got = 2'd2;
        end else if (per_enable != prev_en) begin
          ev = 1'b1; got = {1'b0, per_enable};
        end
        prev_en = per_enable;
        if (ev) begin
          if (exp_q.size() == 0) chk(1'b0, "R3/R5 unexpected event", got, 3);
          else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            chk(got == e, "R3/R5 peripheral event", got, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge bus_clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1'b1; per_rst_n = 1'b1;
    @(negedge bus_clk);
    // R1
    chk(rd_data == 8'h00, "R1 read", rd_data, 0);
    chk(!busy && !lpmux_sel && !stby_run && !per_enable, "R1 outputs",
        {busy, lpmux_sel, stby_run, per_enable}, 0);

    // R2 R7 R3: enable on with both modes
    exp_q.push_back(2'd1);
    wr(8'h86);
    chk(rd_data == 8'h86, "R2 readback", rd_data, 8'h86);
    chk(busy, "R2 busy", busy, 1);
    chk(lpmux_sel && stby_run, "R7 modes", {lpmux_sel, stby_run}, 3);
    chk(!per_enable, "R3 not yet", per_enable, 0);
    wait_idle("R3 busy clears");
    chk(per_enable, "R3 enable on", per_enable, 1);

    // R8: second write while busy
    exp_q.push_back(2'd0);
    wr(8'h80);
    chk(busy && rd_data == 8'h80, "R2 off write", rd_data, 8'h80);
    wr(8'h07);
    chk(rd_data == 8'h04, "R8 low bits ignored", rd_data, 8'h04);
    chk(!lpmux_sel && stby_run, "R7 while busy", {lpmux_sel, stby_run}, 1);
    wait_idle("R8 idle");
    chk(!per_enable, "R3 enable off", per_enable, 0);

    // R6: no transfer on same enable value
    wr(8'h00);
    chk(!busy && rd_data == 8'h00, "R6 no busy", {busy, rd_data}, 0);

    // R9: lock
    lock = 1'b1;
    wr(8'h87);
    chk(rd_data == 8'h00 && !busy && !lpmux_sel, "R9 locked", rd_data, 0);
    lock = 1'b0;

    // R10: reserved bits
    wr(8'h78);
    chk(rd_data == 8'h00, "R10 reserved", rd_data, 0);

    // R4 R5: software reset discards other bits
    exp_q.push_back(2'd1);
    wr(8'h86);
    wait_idle("R3 idle 2");
    exp_q.push_back(2'd2);
    wr(8'h01);
    chk(rd_data == 8'h87, "R4 discard", rd_data, 8'h87);
    chk(busy && lpmux_sel, "R4 busy", {busy, lpmux_sel}, 3);
    wait_idle("R5 idle");
    chk(rd_data == 8'h00, "R5 cleared", rd_data, 0);
    chk(!lpmux_sel && !stby_run && !per_enable, "R5 outputs",
        {lpmux_sel, stby_run, per_enable}, 0);

    // R8: reset request while busy is dropped
    exp_q.push_back(2'd1);
    wr(8'h02);
    wr(8'h01);
    chk(rd_data == 8'h02, "R8 reset ignored", rd_data, 8'h02);
    wait_idle("R8 idle 2");
    chk(per_enable && rd_data == 8'h02, "R8 enable kept", rd_data, 8'h02);

    repeat (20) @(negedge bus_clk);
    chk(exp_q.size() == 0, "R3/R5 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule